// File: doc/BRIEF.md
# Flag-Controlled Arithmetic Logic Unit

This unit is a purely combinational arithmetic logic unit. It takes two operands, `a_in` and `b_in`, and six control bits. Each operand has its own clear bit and invert bit. A select bit chooses between a sum and a bitwise AND of the conditioned operands. A final bit can invert the result. Two status flags come with the result: one says the result is zero, and one says it is negative.

Each operand is conditioned in three steps. The operand is first XORed with its invert bit. The outcome is then masked by the inverse of its clear bit. Last, it is forced to all ones when both bits are set. This gives the same value as clearing first and inverting afterwards, using only gate-level steps. Around the unit, the enclosing processor decodes the six bits from an instruction and stores the result. Neither of those is part of this block. The default width is 16 bits, and the carry out of the adder is discarded.

Top module: `cond_alu`

## Requirements
- R1: The first operand is conditioned by `clr_a` and `inv_a`. When both are 0 it passes unchanged. When `clr_a`=1 and `inv_a`=0 it becomes 0. When `clr_a`=0 and `inv_a`=1 it becomes its bitwise complement. When both are 1 it becomes all ones.
- R2: The second operand is conditioned by `clr_b` and `inv_b`, following the same four cases as R1.
- R3: When `sel_add`=1, the core result is the sum of the conditioned operands modulo 2^W, with the carry out discarded.
- R4: When `sel_add`=0, the core result is the bitwise AND of the conditioned operands.
- R5: When `inv_out`=1, `res` is the bitwise complement of the core result. When `inv_out`=0, `res` equals the core result.
- R6: `is_neg` equals bit W-1 of `res`.
- R7: `is_zero` is 1 exactly when every bit of `res` is 0.
- R8: For all 64 combinations of the six control bits, `res` equals a model that clears an operand first and then inverts it, then adds or ANDs, then optionally inverts the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_in | input | W | First operand |
| b_in | input | W | Second operand |
| clr_a | input | 1 | Clear the first operand |
| inv_a | input | 1 | Invert the first operand |
| clr_b | input | 1 | Clear the second operand |
| inv_b | input | 1 | Invert the second operand |
| sel_add | input | 1 | 1 selects the sum, 0 selects the bitwise AND |
| inv_out | input | 1 | Invert the core result |
| res | output | W | Result |
| is_zero | output | 1 | High when `res` is zero |
| is_neg | output | 1 | Copy of the most significant bit of `res` |

## Verification
The bench builds the unit at its default width of W=16. At that width the values 0x7FFF, 0x8000 and 0xFFFF exercise the sign boundary, the carry wrap out of the top bit and the all-ones forced operand. Every one of the 64 control codes is applied to all pairs drawn from a set of corner operands, and then to a run of random pairs. Each result is compared with a clear-then-invert reference model, which cross-checks the invert-mask-force conditioning order in every case.

// File: rtl/cond_alu.sv
module cond_alu #(
  parameter int W = 16
) (
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  input  logic         clr_a,
  input  logic         inv_a,
  input  logic         clr_b,
  input  logic         inv_b,
  input  logic         sel_add,
  input  logic         inv_out,
  output logic [W-1:0] res,
  output logic         is_zero,
  output logic         is_neg
);

  logic [W-1:0] a_x, a_m, a_c;
  logic [W-1:0] b_x, b_m, b_c;
  logic [W-1:0] core;

  assign a_x = a_in ^ {W{inv_a}};
  assign a_m = a_x & {W{~clr_a}};
  assign a_c = a_m | {W{inv_a & clr_a}};

  assign b_x = b_in ^ {W{inv_b}};
  assign b_m = b_x & {W{~clr_b}};
  assign b_c = b_m | {W{inv_b & clr_b}};

  assign core    = sel_add ? (a_c + b_c) : (a_c & b_c);
  assign res     = core ^ {W{inv_out}};
  assign is_neg  = res[W-1];
  assign is_zero = ~(|res);

endmodule

// File: rtl/cond_alu_chk.sv
module cond_alu_chk #(
  parameter int W = 16
) (
  input logic [W-1:0] a_in,
  input logic [W-1:0] b_in,
  input logic         clr_a,
  input logic         inv_a,
  input logic         clr_b,
  input logic         inv_b,
  input logic         sel_add,
  input logic         inv_out,
  input logic [W-1:0] res,
  input logic         is_zero,
  input logic         is_neg
);

  logic [5:0] code;
  assign code = {clr_a, inv_a, clr_b, inv_b, sel_add, inv_out};

  always_comb begin
    // R1
    pass_a_chk: assert (code != 6'b001100 || res == a_in);
    // R2
    pass_b_chk: assert (code != 6'b110000 || res == b_in);
    // R3
    minus_two_chk: assert (code != 6'b111110 || res == {{(W-1){1'b1}}, 1'b0});
    // R4
    and_clear_chk: assert (code != 6'b100000 || res == '0);
    // R5
    inv_ones_chk: assert (code != 6'b100001 || res == '1);
    // R6
    flags_excl_chk: assert (!(is_zero && is_neg));
    // R7
    zero_flag_chk: assert (is_zero == (res == '0));
    // R8
    neg_one_chk: assert (code != 6'b111010 || res == '1);
  end

endmodule

bind cond_alu cond_alu_chk #(.W(W)) u_chk (.*);

// File: tb/cond_alu_bench.sv
module cond_alu_bench;
  localparam int W = 16;

  typedef struct {
    logic [W-1:0] r;
    logic         z;
    logic         n;
    string        tag;
    logic [5:0]   code;
  } exp_t;

  logic clk = 0;
  logic rst = 1;
  always #5 clk = ~clk;

  logic [W-1:0] a_in = '0, b_in = '0;
  logic clr_a = 0, inv_a = 0, clr_b = 0, inv_b = 0, sel_add = 0, inv_out = 0;
  logic [W-1:0] res;
  logic is_zero, is_neg;

  cond_alu #(.W(W)) u_cond_alu (.*);

  exp_t q[$];
  int checks = 0;
  int fails  = 0;
  bit done = 0;

  function automatic logic [W-1:0] model(input logic [W-1:0] a, b, input logic [5:0] c);
    logic [W-1:0] x, y, t;
    x = c[5] ? '0 : a;
    x = c[4] ? ~x : x;
    y = c[3] ? '0 : b;
    y = c[2] ? ~y : y;
    t = c[1] ? x + y : x & y;
    return c[0] ? ~t : t;
  endfunction

  task automatic drive(input logic [W-1:0] a, b, input logic [5:0] c, input string tag);
    exp_t e;
    @(posedge clk);
    #1;
    a_in = a; b_in = b;
    {clr_a, inv_a, clr_b, inv_b, sel_add, inv_out} = c;
    e.r = model(a, b, c);
    e.z = (e.r == '0);
    e.n = e.r[W-1];
    e.tag = tag;
    e.code = c;
    q.push_back(e);
  endtask

  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (res !== e.r) begin
        fails++;
        $display("FAIL %s res code=%b actual=%h expected=%h", e.tag, e.code, res, e.r);
      end
      checks++;
      if (is_zero !== e.z) begin
        fails++;
        $display("FAIL R7 is_zero code=%b actual=%b expected=%b", e.code, is_zero, e.z);
      end
      checks++;
      if (is_neg !== e.n) begin
        fails++;
        $display("FAIL R6 is_neg code=%b actual=%b expected=%b", e.code, is_neg, e.n);
      end
    end
  end

  function automatic string tag_of(input logic [5:0] c);
    if (c[0]) return "R5";
    if (c[1]) return "R3";
    return "R4";
  endfunction

  logic [W-1:0] corner [5] = '{16'h0000, 16'h0001, 16'h7FFF, 16'h8000, 16'hFFFF};

  initial begin
    fork
      begin
        #1_500_000;
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        done = 1;
      end
      begin
        repeat (3) @(posedge clk);
        rst = 0;
        // reset-state style: all controls clear, zero operands -> zero, R7
        drive('0, '0, 6'b000000, "R7");
        // R1: each conditioning case on the first operand, second forced to ones
        drive(16'h1234, 16'h0000, 6'b001100, "R1");
        drive(16'h1234, 16'h0000, 6'b101100, "R1");
        drive(16'h1234, 16'h0000, 6'b011100, "R1");
        drive(16'h1234, 16'h0000, 6'b111100, "R1");
        // R2: the same for the second operand
        drive(16'h0000, 16'hA5C3, 6'b110000, "R2");
        drive(16'h0000, 16'hA5C3, 6'b110100, "R2");
        drive(16'h0000, 16'hA5C3, 6'b111000, "R2");
        drive(16'h0000, 16'hA5C3, 6'b111100, "R2");
        // R3: carry wrap out of the top bit
        drive(16'hFFFF, 16'h0001, 6'b000010, "R3");
        drive(16'h8000, 16'h8000, 6'b000010, "R3");
        drive(16'h7FFF, 16'h0001, 6'b000010, "R3");
        // R8: every control code over corner and random operands
        for (int c = 0; c < 64; c++) begin
          for (int i = 0; i < 5; i++)
            for (int j = 0; j < 5; j++)
              drive(corner[i], corner[j], 6'(c), "R8");
          for (int k = 0; k < 8; k++)
            drive(W'($urandom), W'($urandom), 6'(c), tag_of(6'(c)));
        end
        @(posedge clk);
        @(posedge clk);
        done = 1;
      end
    join_any
    disable fork;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule